// File: doc/BRIEF.md
# Accumulator Processor Micro-Operation Sequencer

This block is the control unit and register datapath of a small multi-cycle accumulator processor. It holds a program counter, a memory address register, a memory buffer register, an instruction register and an accumulator. These registers reach one single-port synchronous memory through an address bus, a write-data bus, a read-data bus, a read strobe and a write strobe.

Every instruction passes through cycle groups in a fixed order: fetch, then indirect when the instruction asks for it, then execute, then interrupt when one is due. Each group lasts exactly three steps. Within a step the register transfers are arranged so that no register is both read and written. The program counter increment shares a step with the instruction read.

The memory samples the address and the read strobe on the same clock edge that loads the memory address register. Read data therefore appears in the next step, and the memory buffer register captures it at the end of that step.

The instruction word is 16 bits wide:
- bits 15..12 hold the opcode;
- bit 11 is the indirect flag;
- bits 10..0 hold the address field.

Top module: `ucode_acc_cpu`

## Requirements
- R1: While reset is held, pc_o is 0x020, acc_o is 0, int_en is 1, grp_o is 0 and stp_o is 0. The group codes are 0 = fetch, 1 = indirect, 2 = execute and 3 = interrupt. stp_o counts 0, 1, 2 within each group.
- R2: Fetch takes three steps.
  - In step 0, mem_rd is 1 and mem_addr equals pc_o.
  - At the end of step 1, pc_o increases by exactly 1.
  - At the end of step 2, ir_o holds the word that was read.
- R3: When bit 11 of the fetched word is 1, an indirect group follows fetch. It reads the word at the address field and replaces ir_o[10:0] with bits 10..0 of that word. The instruction then acts as a direct one. When bit 11 is 0, execute follows fetch directly.
- R4: LOAD (opcode 0001) sets the accumulator to the word at the effective address. ADD (opcode 0011) adds that word to the accumulator modulo 2^16. Both take effect at the end of execute step 2.
- R5: STORE (opcode 0010) writes the accumulator to the effective address. The write happens in execute step 2.
- R6: JUMP (opcode 0100) loads pc_o with the address field at the end of execute step 0.
- R7: At the end of execute, the interrupt group is entered only if a request is pending and int_en is 1. Entering it clears int_en. The group writes the return pc_o to address 0x000 in its step 2, and pc_o becomes 0x010 at the end of its step 1.
- R8: An irq pulse is registered as pending and held until it is serviced. RETI (opcode 0101) restores pc_o from address 0x000 and sets int_en. A request pending during RETI is taken at the end of the next instruction. A request first sampled on the edge that closes execute is taken one instruction later.
- R9: mem_wr is 1 only in execute step 2 of STORE and in interrupt step 2. Groups run in the order fetch, indirect, execute, interrupt, and are then followed by fetch.
- R10: Opcodes 0000 and 0110 to 1111 spend three idle execute steps. They change neither the accumulator nor memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt request, sampled each clock |
| mem_rdata | input | 16 | Read data, valid one step after a read launch |
| mem_addr | output | 11 | Memory address, sampled with the strobes |
| mem_wdata | output | 16 | Write data (memory buffer register) |
| mem_rd | output | 1 | Read launch strobe |
| mem_wr | output | 1 | Write strobe |
| pc_o | output | 11 | Program counter |
| acc_o | output | 16 | Accumulator |
| ir_o | output | 16 | Instruction register |
| int_en | output | 1 | Interrupt-enable flag |
| grp_o | output | 2 | Current cycle group |
| stp_o | output | 2 | Current step within the group |

## Verification
Two events can coincide with the step that closes execute: a new interrupt request arriving, and RETI setting the enable flag again. The bench places an irq pulse exactly on the last execute edge, and checks that the interrupt group is entered one instruction later rather than at once. It also raises a request inside the handler while the enable flag is clear. It then checks that the group is skipped at the end of RETI and entered at the end of the following instruction, with the return address written to 0x000 each time.

// File: rtl/ucode_acc_cpu.sv
module ucode_acc_cpu #(
  parameter int AW        = 11,
  parameter int OPW       = 4,
  parameter int RESET_PC  = 32,
  parameter int SAVE_ADDR = 0,
  parameter int ISR_ADDR  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  irq,
  input  logic [OPW+AW:0]       mem_rdata,
  output logic [AW-1:0]         mem_addr,
  output logic [OPW+AW:0]       mem_wdata,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic [AW-1:0]         pc_o,
  output logic [OPW+AW:0]       acc_o,
  output logic [OPW+AW:0]       ir_o,
  output logic                  int_en,
  output logic [1:0]            grp_o,
  output logic [1:0]            stp_o
);
  localparam int DW = OPW + AW + 1;
  localparam logic [1:0] G_FET = 2'd0, G_IND = 2'd1, G_EXE = 2'd2, G_INT = 2'd3;
  localparam logic [OPW-1:0] OP_LD = OPW'(1), OP_ST = OPW'(2), OP_ADD = OPW'(3),
                             OP_JMP = OPW'(4), OP_RTI = OPW'(5);

  logic [AW-1:0] pc, mar, mar_nx;
  logic [DW-1:0] mbr, ir, acc;
  logic [1:0]    grp, stp;
  logic          ie, pend;

  wire [OPW-1:0] opc   = ir[DW-1 -: OPW];
  wire [AW-1:0]  adr   = ir[AW-1:0];
  wire           s0    = (stp == 2'd0);
  wire           s1    = (stp == 2'd1);
  wire           s2    = (stp == 2'd2);
  wire           exe   = (grp == G_EXE);
  wire           rd_op = (opc == OP_LD) || (opc == OP_ADD) || (opc == OP_RTI);
  wire           take  = exe && s2 && pend && ie;

  always_comb begin
    mar_nx = mar;
    if (s0 && (grp == G_FET)) mar_nx = pc;
    else if (s0 && (grp == G_IND)) mar_nx = adr;
    else if (s0 && exe && (opc == OP_RTI)) mar_nx = AW'(SAVE_ADDR);
    else if (s0 && exe && (rd_op || opc == OP_ST)) mar_nx = adr;
    else if (s1 && (grp == G_INT)) mar_nx = AW'(SAVE_ADDR);
  end

  assign mem_rd    = s0 && ((grp == G_FET) || (grp == G_IND) || (exe && rd_op));
  assign mem_wr    = s2 && ((exe && opc == OP_ST) || (grp == G_INT));
  assign mem_addr  = mar_nx;
  assign mem_wdata = mbr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc   <= AW'(RESET_PC);
      mar  <= '0;
      mbr  <= '0;
      ir   <= '0;
      acc  <= '0;
      grp  <= G_FET;
      stp  <= 2'd0;
      ie   <= 1'b1;
      pend <= 1'b0;
    end else begin
      mar  <= mar_nx;
      pend <= irq || (pend && !take);
      stp  <= s2 ? 2'd0 : stp + 2'd1;
      case (grp)
        G_FET: begin
          if (s1) begin
            mbr <= mem_rdata;
            pc  <= pc + AW'(1);
          end
          if (s2) begin
            ir  <= mbr;
            grp <= mbr[AW] ? G_IND : G_EXE;
          end
        end
        G_IND: begin
          if (s1) mbr <= mem_rdata;
          if (s2) begin
            ir[AW-1:0] <= mbr[AW-1:0];
            grp        <= G_EXE;
          end
        end
        G_EXE: begin
          if (s0 && opc == OP_JMP) pc <= adr;
          if (s1 && rd_op) mbr <= mem_rdata;
          if (s1 && opc == OP_ST) mbr <= acc;
          if (s2) begin
            if (opc == OP_LD)  acc <= mbr;
            if (opc == OP_ADD) acc <= acc + mbr;
            if (opc == OP_RTI) pc  <= mbr[AW-1:0];
            if (take) ie <= 1'b0;
            else if (opc == OP_RTI) ie <= 1'b1;
            grp <= take ? G_INT : G_FET;
          end
        end
        default: begin
          if (s0) mbr <= {{(DW-AW){1'b0}}, pc};
          if (s1) pc  <= AW'(ISR_ADDR);
          if (s2) grp <= G_FET;
        end
      endcase
    end
  end

  assign pc_o   = pc;
  assign acc_o  = acc;
  assign ir_o   = ir;
  assign int_en = ie;
  assign grp_o  = grp;
  assign stp_o  = stp;
endmodule

// File: rtl/ucode_acc_cpu_chk.sv
module ucode_acc_cpu_chk #(
  parameter int AW        = 11,
  parameter int OPW       = 4,
  parameter int SAVE_ADDR = 0
) (
  input logic           clk,
  input logic           rst_n,
  input logic [AW-1:0]  pc_o,
  input logic [OPW-1:0] op,
  input logic [AW-1:0]  adr,
  input logic           int_en,
  input logic [1:0]     grp_o,
  input logic [1:0]     stp_o,
  input logic [AW-1:0]  mem_addr,
  input logic           mem_rd,
  input logic           mem_wr
);
  a_r2_fetch_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_o == 2'd0 && stp_o == 2'd0) |-> (mem_rd && mem_addr == pc_o));

  a_r2_pc_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_o == 2'd0 && stp_o == 2'd1) |=> (pc_o == $past(pc_o) + AW'(1)));

  a_r3_ind_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_o == 2'd1 && stp_o == 2'd2) |=> (grp_o == 2'd2 && stp_o == 2'd0));

  a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_o == 2'd2 && stp_o == 2'd0 && op == OPW'(4)) |=> (pc_o == $past(adr)));

  a_r7_ie_low_in_int: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_o == 2'd3) |-> !int_en);

  a_r7_save_write: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_o == 2'd3 && stp_o == 2'd2) |-> (mem_wr && mem_addr == AW'(SAVE_ADDR)));

  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_o == 2'd2 && stp_o == 2'd2 && !int_en) |=> (grp_o != 2'd3));

  a_r9_wr_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (stp_o == 2'd2 && grp_o[1]));

  a_r9_int_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_o == 2'd3 && stp_o == 2'd2) |=> (grp_o == 2'd0 && stp_o == 2'd0));
endmodule

bind ucode_acc_cpu ucode_acc_cpu_chk #(.AW(AW), .OPW(OPW), .SAVE_ADDR(SAVE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_o(pc_o), .op(ir_o[OPW+AW -: OPW]), .adr(ir_o[AW-1:0]),
  .int_en(int_en), .grp_o(grp_o), .stp_o(stp_o), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/sim_ucode_acc_cpu.sv
`timescale 1ns/1ps
module sim_ucode_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] mem_rdata, mem_wdata, acc_o, ir_o;
  logic [10:0] mem_addr, pc_o;
  logic        mem_rd, mem_wr, int_en;
  logic [1:0]  grp_o, stp_o;

  logic        tb_we = 1'b0;
  logic [10:0] tb_addr = '0;
  logic [15:0] tb_data = '0;
  logic [15:0] mem [0:2047];
  int          wr_cnt, bad_wr;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  ucode_acc_cpu u0 (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .pc_o(pc_o), .acc_o(acc_o), .ir_o(ir_o), .int_en(int_en),
    .grp_o(grp_o), .stp_o(stp_o)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_addr] <= tb_data;
    else if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt <= 0;
      bad_wr <= 0;
    end else if (mem_wr) begin
      wr_cnt <= wr_cnt + 1;
      if (!(stp_o == 2'd2 && (grp_o == 2'd3 || (grp_o == 2'd2 && ir_o[15:12] == 4'd2))))
        bad_wr <= bad_wr + 1;
    end
  end

  function automatic logic [15:0] enc(input logic [3:0] op, input logic ind, input logic [10:0] a);
    return {op, ind, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    irq   = 1'b0;
    steps(2);
  endtask

  task automatic poke(input logic [10:0] a, input logic [15:0] d);
    tb_addr = a;
    tb_data = d;
    tb_we   = 1'b1;
    steps(1);
    tb_we   = 1'b0;
  endtask

  task automatic go();
    rst_n = 1'b1;
  endtask

  task automatic pulse_irq();
    irq = 1'b1;
    steps(1);
    irq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset values and R2 fetch schedule
    hold_reset();
    poke(11'h020, enc(4'd1, 1'b0, 11'h100));
    poke(11'h021, enc(4'd4, 1'b0, 11'h021));
    poke(11'h100, 16'h1234);
    chk("R1 pc", pc_o, 11'h020);
    chk("R1 acc", acc_o, 0);
    chk("R1 ie", int_en, 1);
    chk("R1 grp/stp", {grp_o, stp_o}, 0);
    go();
    chk("R2 launch rd", mem_rd, 1);
    chk("R2 launch addr", mem_addr, 11'h020);
    steps(1);
    chk("R2 pc held in step1", pc_o, 11'h020);
    steps(1);
    chk("R2 pc+1", pc_o, 11'h021);
    steps(1);
    chk("R2 ir loaded", ir_o, enc(4'd1, 1'b0, 11'h100));
    chk("R3 direct goes to exec", grp_o, 2);
    steps(3);
    chk("R4 load", acc_o, 16'h1234);
    chk("R9 fetch after exec", {grp_o, stp_o}, 0);

    // R3 R4 R5 sweep: direct and indirect operands, with carry-out wrap
    for (int k = 0; k < 16; k++) begin
      logic [15:0] a, b, s;
      logic [10:0] dst;
      bit ia, is;
      a  = 16'(k * 16'h1357 + 3);
      b  = 16'(16'hF000 + k * 16'h0111);
      s  = a + b;
      ia = k[0];
      is = k[1];
      dst = is ? 11'h103 : 11'h102;
      hold_reset();
      poke(11'h020, enc(4'd1, 1'b0, 11'h100));
      poke(11'h021, enc(4'd3, ia, ia ? 11'h180 : 11'h101));
      poke(11'h022, enc(4'd2, is, is ? 11'h181 : 11'h102));
      poke(11'h023, enc(4'd4, 1'b0, 11'h023));
      poke(11'h100, a);
      poke(11'h101, b);
      poke(11'h102, 16'h0);
      poke(11'h103, 16'h0);
      poke(11'h180, 16'hF101);
      poke(11'h181, 16'hE103);
      go();
      steps(40);
      chk("R4 add acc", acc_o, s);
      chk("R5 store", mem[dst], s);
      chk("R3 indirect operand untouched", mem[11'h180], 16'hF101);
    end

    // R3 indirect timing: nine steps, address field replaced
    hold_reset();
    poke(11'h020, enc(4'd1, 1'b1, 11'h180));
    poke(11'h180, 16'hF101);
    poke(11'h101, 16'h0BEE);
    go();
    steps(3);
    chk("R3 indirect group", grp_o, 1);
    steps(3);
    chk("R3 address replaced", ir_o[10:0], 11'h101);
    chk("R3 exec after indirect", grp_o, 2);
    steps(3);
    chk("R3 indirect load", acc_o, 16'h0BEE);

    // R6 jump
    hold_reset();
    poke(11'h020, enc(4'd4, 1'b0, 11'h040));
    poke(11'h021, enc(4'd1, 1'b0, 11'h100));
    poke(11'h040, enc(4'd1, 1'b0, 11'h101));
    poke(11'h041, enc(4'd4, 1'b0, 11'h041));
    poke(11'h100, 16'h1111);
    poke(11'h101, 16'h2222);
    go();
    steps(4);
    chk("R6 pc after exec step0", pc_o, 11'h040);
    steps(20);
    chk("R6 target executed", acc_o, 16'h2222);

    // R10 undefined opcodes
    hold_reset();
    poke(11'h020, enc(4'd1, 1'b0, 11'h100));
    poke(11'h021, enc(4'd0, 1'b0, 11'h100));
    poke(11'h022, enc(4'd6, 1'b0, 11'h100));
    poke(11'h023, enc(4'd15, 1'b0, 11'h100));
    poke(11'h024, enc(4'd4, 1'b0, 11'h024));
    poke(11'h100, 16'h5A5A);
    go();
    steps(40);
    chk("R10 acc kept", acc_o, 16'h5A5A);
    chk("R10 no writes", wr_cnt, 0);
    chk("R10 mem kept", mem[11'h100], 16'h5A5A);

    // R7 R8 interrupt entry, masking while in handler, RETI
    hold_reset();
    poke(11'h000, 16'h0);
    poke(11'h010, enc(4'd2, 1'b0, 11'h110));
    poke(11'h011, enc(4'd5, 1'b0, 11'h000));
    poke(11'h020, enc(4'd1, 1'b0, 11'h100));
    poke(11'h021, enc(4'd4, 1'b0, 11'h021));
    poke(11'h100, 16'h7777);
    poke(11'h110, 16'h0);
    go();
    steps(2);
    pulse_irq();
    steps(3);
    chk("R7 int group", grp_o, 3);
    chk("R7 ie cleared", int_en, 0);
    steps(2);
    chk("R7 pc to handler", pc_o, 11'h010);
    steps(1);
    chk("R7 return saved", mem[11'h000], 16'h0021);
    chk("R9 fetch after int", {grp_o, stp_o}, 0);
    steps(3);
    pulse_irq();
    steps(2);
    chk("R5 handler store", mem[11'h110], 16'h7777);
    steps(6);
    chk("R8 reti pc", pc_o, 11'h021);
    chk("R8 reti ie", int_en, 1);
    chk("R8 no entry at reti", grp_o, 0);
    steps(6);
    chk("R8 pending taken next", grp_o, 3);
    steps(3);
    chk("R8 pc at handler", pc_o, 11'h010);
    chk("R9 write slots", bad_wr, 0);
    chk("R7 write count", wr_cnt, 3);

    // R8 request sampled on the edge closing execute is deferred
    hold_reset();
    poke(11'h020, enc(4'd1, 1'b0, 11'h100));
    poke(11'h021, enc(4'd4, 1'b0, 11'h021));
    poke(11'h100, 16'h0042);
    go();
    steps(5);
    pulse_irq();
    chk("R8 same-edge not taken", grp_o, 0);
    steps(6);
    chk("R8 taken one instr later", grp_o, 3);
    steps(3);
    chk("R7 saved after jump", mem[11'h000], 16'h0021);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule